// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table in memory. A requester presents a virtual address with write and user qualifiers. The walker fetches the directory entry, and in most cases a table entry too, through a memory port that carries one access at a time. It sets the accessed and dirty flags in the entries it uses, writing an entry back only when a flag actually changes.

It finishes each walk with a one-cycle completion pulse. The pulse carries either a physical address with read, write and execute grants, or a fault with a three-bit error code. On a fault it also keeps the faulting virtual address on a dedicated output.

The paging control word, the table base, the extension control word and an address-line mask are inputs, sampled live during a walk. The walker can hand out a 4 MiB mapping straight from a directory entry. It grants write access only to pages that are already dirty, so the first store to a clean page always comes back through the walker and marks it.

Top module: `xlate_walker`

## Requirements
- R1: When bit 31 of `cr0` is 0, a request completes with no memory access. The result is a physical address whose bits 31:12 are `req_vaddr & a20_mask` and whose bits 11:0 are `req_vaddr[11:0]`, with read, write and execute all granted and no fault.
- R2: The first read of a walk is to address ((`cr3` with bits 11:0 cleared) + 4 × vaddr[31:22]) & `a20_mask`.
- R3: The table entry read is to address ((directory entry with bits 11:0 cleared) + 4 × vaddr[21:12]) & `a20_mask`. The physical address of a 4 KiB page is (table entry & `a20_mask`)[31:12] joined to vaddr[11:0].
- R4: If entry bit 0 (present) is 0 in the directory or the table entry, the walk faults with error-code bit 0 equal to 0. No further access is made.
- R5: When directory entry bit 7 is 1 and `cr4` bit 4 is 1, the walk makes no table read. The page is 4 MiB, with physical address (entry & `a20_mask`)[31:22] joined to vaddr[21:0]. When `cr4` bit 4 is 0, bit 7 is ignored and the table is read.
- R6: The effective user bit (entry bit 2) and writable bit (entry bit 1) are the AND of both levels. A user access faults with error-code bit 0 = 1 if the effective user bit is 0, or if it is a write and the effective writable bit is 0.
- R7: A supervisor write to a page whose effective writable bit is 0 faults only when `cr0` bit 16 is 1.
- R8: On the 4 KiB path, a directory entry whose bit 5 (accessed) is 0 is written back with bit 5 set before the table read. A directory entry already marked accessed is not written.
- R9: The final entry gets bit 5 set, and on a write bit 6 (dirty) as well. It is written back only if its value changed. A walk that faults makes no write-back of the final entry.
- R10: A successful walk always grants read and execute. It grants write only if the final entry's bit 6 is 1 after the update, and either the access is user with effective writable 1, or it is supervisor with `cr0` bit 16 = 0 or effective writable 1.
- R11: On a fault, `fault_code` bit 0 = protection violation, bit 1 = write access, bit 2 = user access, and `fault_addr` takes the virtual address. A successful walk leaves `fault_addr` unchanged.
- R12: `req_ready` is high only when idle, and a request is taken only then. `done` is a one-cycle pulse per request. A memory request holds its address until `mem_ack`, and `req_valid` during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| cr0 | input | 32 | Paging control word (bit 31 enable, bit 16 write-protect) |
| cr3 | input | 32 | Directory base address |
| cr4 | input | 32 | Extension control word (bit 4 large pages) |
| a20_mask | input | 32 | Mask applied to every physical address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completed, read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (valid with done) |
| fault_code | output | 3 | Error code: protection, write, user |
| fault_addr | output | 32 | Last faulting virtual address |
| res_paddr | output | 32 | Translated physical address |
| res_r | output | 1 | Read granted |
| res_w | output | 1 | Write granted |
| res_x | output | 1 | Execute granted |

## Verification
Several rules are checked on every cycle by assertions. The completion pulse lasts one cycle, a pending memory access keeps its address and direction until acknowledged, and every write-back carries the present and accessed flags. The faulting-address output moves only together with a faulting completion. The sequence of entry addresses, the write-back decisions, the merged permissions and the write-protect, large-page and address-mask cases depend on table contents. Only the bench's scenarios show these, by comparing each memory access and each completion against a behavioural model of the walk.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   // Entry flag positions
   localparam int PTE_P  = 0;
   localparam int PTE_RW = 1;
   localparam int PTE_US = 2;
   localparam int PTE_A  = 5;
   localparam int PTE_D  = 6;
   localparam int PTE_PS = 7;
   // Control word bit positions
   localparam int CR0_WP  = 16;
   localparam int CR0_PG  = 31;
   localparam int CR4_PSE = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_DIR_WB,
      ST_TBL_RD,
      ST_TBL_WB,
      ST_DONE
   } walk_st_e;
endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int OFF_BITS    = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_SHIFT = 2
) (
   input  logic [ADDR_W-OFF_BITS-1:0] base_frame,
   input  logic [IDX_W-1:0]           idx,
   input  logic [ADDR_W-1:0]          a20,
   output logic [ADDR_W-1:0]          entry_addr
);
   logic [ADDR_W-1:0] base_full;
   logic [ADDR_W-1:0] idx_off;

   assign base_full  = {base_frame, {OFF_BITS{1'b0}}};
   assign idx_off    = ADDR_W'(idx) << ENTRY_SHIFT;
   assign entry_addr = (base_full + idx_off) & a20;
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm (
   input  logic eff_rw,
   input  logic eff_us,
   input  logic is_write,
   input  logic is_user,
   input  logic wp,
   input  logic dirty_after,
   output logic prot_fault,
   output logic grant_w
);
   always_comb begin
      if (is_user) begin
         prot_fault = !eff_us || (is_write && !eff_rw);
         grant_w    = dirty_after && eff_rw;
      end else begin
         prot_fault = wp && is_write && !eff_rw;
         grant_w    = dirty_after && (!wp || eff_rw);
      end
   end
endmodule

// File: rtl/xlate_ad_update.sv
module xlate_ad_update
   import xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] entry_in,
   input  logic              is_write,
   output logic [ADDR_W-1:0] entry_out,
   output logic              changed
);
   localparam logic [ADDR_W-1:0] A_BIT = ADDR_W'(1) << PTE_A;
   localparam logic [ADDR_W-1:0] D_BIT = ADDR_W'(1) << PTE_D;

   assign entry_out = entry_in | A_BIT | (is_write ? D_BIT : '0);
   assign changed   = (entry_out != entry_in);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
   import xlate_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DIR_BITS      = 10,
   parameter int TBL_BITS      = 10,
   parameter int OFF_BITS      = 12,
   parameter bit LARGE_PAGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [31:0]       cr0,
   input  logic [ADDR_W-1:0] cr3,
   input  logic [31:0]       cr4,
   input  logic [ADDR_W-1:0] a20_mask,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              done,
   output logic              fault,
   output logic [2:0]        fault_code,
   output logic [ADDR_W-1:0] fault_addr,
   output logic [ADDR_W-1:0] res_paddr,
   output logic              res_r,
   output logic              res_w,
   output logic              res_x
);
   localparam int FRAME_W   = ADDR_W - OFF_BITS;
   localparam int LARGE_OFF = TBL_BITS + OFF_BITS;
   localparam int DIR_LO    = LARGE_OFF;
   localparam logic [ADDR_W-1:0] A_BIT = ADDR_W'(1) << PTE_A;

   // Elaboration-time parameter checks
   if (DIR_BITS + TBL_BITS + OFF_BITS != ADDR_W) begin : g_bad_split
      $error("xlate_walker: index and offset widths must sum to ADDR_W");
   end
   if (OFF_BITS <= PTE_PS) begin : g_bad_off
      $error("xlate_walker: offset must cover all entry flag bits");
   end
   if (ADDR_W > 32) begin : g_bad_width
      $error("xlate_walker: entries are at most 32 bits wide");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q, usr_q, big_q;
   logic [FRAME_W-1:0] pde_frame_q;
   logic              pde_rw_q, pde_us_q;
   logic [ADDR_W-1:0] wb_q;
   logic [ADDR_W-1:0] paddr_q, cr2_q;
   logic              fault_q;
   logic [2:0]        code_q;
   logic [2:0]        perm_q;

   logic [ADDR_W-1:0] dir_addr, tbl_addr, upd;
   logic              ad_changed, prot_fault, grant_w, big_hit, in_tbl;
   logic              eff_rw, eff_us;
   logic [FRAME_W-1:0] rd_frame_m;
   logic [ADDR_W-1:0] paddr_small, paddr_big, paddr_off, va_in_m;

   xlate_addr_gen #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_W(DIR_BITS), .ENTRY_SHIFT(2)) u_dir_ag (
      .base_frame (cr3[ADDR_W-1:OFF_BITS]),
      .idx        (va_q[ADDR_W-1:DIR_LO]),
      .a20        (a20_mask),
      .entry_addr (dir_addr)
   );

   xlate_addr_gen #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_W(TBL_BITS), .ENTRY_SHIFT(2)) u_tbl_ag (
      .base_frame (pde_frame_q),
      .idx        (va_q[LARGE_OFF-1:OFF_BITS]),
      .a20        (a20_mask),
      .entry_addr (tbl_addr)
   );

   assign in_tbl = (st_q == ST_TBL_RD);
   assign eff_rw = mem_rdata[PTE_RW] & (!in_tbl | pde_rw_q);
   assign eff_us = mem_rdata[PTE_US] & (!in_tbl | pde_us_q);

   xlate_ad_update #(.ADDR_W(ADDR_W)) u_ad (
      .entry_in  (mem_rdata),
      .is_write  (wr_q),
      .entry_out (upd),
      .changed   (ad_changed)
   );

   xlate_perm u_perm (
      .eff_rw      (eff_rw),
      .eff_us      (eff_us),
      .is_write    (wr_q),
      .is_user     (usr_q),
      .wp          (cr0[CR0_WP]),
      .dirty_after (upd[PTE_D]),
      .prot_fault  (prot_fault),
      .grant_w     (grant_w)
   );

   if (LARGE_PAGE_EN) begin : g_large
      assign big_hit = mem_rdata[PTE_PS] & cr4[CR4_PSE];
   end else begin : g_small_only
      assign big_hit = 1'b0;
   end

   assign rd_frame_m  = mem_rdata[ADDR_W-1:OFF_BITS] & a20_mask[ADDR_W-1:OFF_BITS];
   assign paddr_small = {rd_frame_m, va_q[OFF_BITS-1:0]};
   assign paddr_big   = {rd_frame_m[FRAME_W-1:TBL_BITS], va_q[LARGE_OFF-1:0]};
   assign va_in_m     = req_vaddr & a20_mask;
   assign paddr_off   = {va_in_m[ADDR_W-1:OFF_BITS], req_vaddr[OFF_BITS-1:0]};

   logic unused_ctrl;
   assign unused_ctrl = ^{cr0, cr3[OFF_BITS-1:0], cr4};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         big_q       <= 1'b0;
         pde_frame_q <= '0;
         pde_rw_q    <= 1'b0;
         pde_us_q    <= 1'b0;
         wb_q        <= '0;
         paddr_q     <= '0;
         cr2_q       <= '0;
         fault_q     <= 1'b0;
         code_q      <= '0;
         perm_q      <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q  <= req_vaddr;
                  wr_q  <= req_write;
                  usr_q <= req_user;
                  if (!cr0[CR0_PG]) begin
                     paddr_q <= paddr_off;
                     perm_q  <= 3'b111;
                     fault_q <= 1'b0;
                     code_q  <= '0;
                     st_q    <= ST_DONE;
                  end else begin
                     st_q <= ST_DIR_RD;
                  end
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  if (!mem_rdata[PTE_P]) begin
                     fault_q <= 1'b1;
                     code_q  <= {usr_q, wr_q, 1'b0};
                     cr2_q   <= va_q;
                     st_q    <= ST_DONE;
                  end else if (big_hit) begin
                     if (prot_fault) begin
                        fault_q <= 1'b1;
                        code_q  <= {usr_q, wr_q, 1'b1};
                        cr2_q   <= va_q;
                        st_q    <= ST_DONE;
                     end else begin
                        fault_q <= 1'b0;
                        code_q  <= '0;
                        paddr_q <= paddr_big;
                        perm_q  <= {1'b1, grant_w, 1'b1};
                        big_q   <= 1'b1;
                        wb_q    <= upd;
                        st_q    <= ad_changed ? ST_DIR_WB : ST_DONE;
                     end
                  end else begin
                     pde_frame_q <= mem_rdata[ADDR_W-1:OFF_BITS];
                     pde_rw_q    <= mem_rdata[PTE_RW];
                     pde_us_q    <= mem_rdata[PTE_US];
                     big_q       <= 1'b0;
                     wb_q        <= mem_rdata | A_BIT;
                     st_q        <= mem_rdata[PTE_A] ? ST_TBL_RD : ST_DIR_WB;
                  end
               end
            end
            ST_DIR_WB: begin
               if (mem_ack) st_q <= big_q ? ST_DONE : ST_TBL_RD;
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  if (!mem_rdata[PTE_P] || prot_fault) begin
                     fault_q <= 1'b1;
                     code_q  <= {usr_q, wr_q, mem_rdata[PTE_P]};
                     cr2_q   <= va_q;
                     st_q    <= ST_DONE;
                  end else begin
                     fault_q <= 1'b0;
                     code_q  <= '0;
                     paddr_q <= paddr_small;
                     perm_q  <= {1'b1, grant_w, 1'b1};
                     wb_q    <= upd;
                     st_q    <= ad_changed ? ST_TBL_WB : ST_DONE;
                  end
               end
            end
            ST_TBL_WB: begin
               if (mem_ack) st_q <= ST_DONE;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign mem_req    = (st_q == ST_DIR_RD) || (st_q == ST_DIR_WB) ||
                       (st_q == ST_TBL_RD) || (st_q == ST_TBL_WB);
   assign mem_we     = (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
   assign mem_addr   = ((st_q == ST_DIR_RD) || (st_q == ST_DIR_WB)) ? dir_addr : tbl_addr;
   assign mem_wdata  = wb_q;
   assign done       = (st_q == ST_DONE);
   assign fault      = fault_q;
   assign fault_code = code_q;
   assign fault_addr = cr2_q;
   assign res_paddr  = paddr_q;
   assign res_r      = perm_q[0];
   assign res_w      = perm_q[1];
   assign res_x      = perm_q[2];

   // Completion is a single-cycle pulse
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // A pending access keeps its address and direction until acknowledged
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // Every write-back carries a present, accessed entry
   assert_wb_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[PTE_A] && mem_wdata[PTE_P]));

   // The faulting address moves only with a faulting completion
   assert_cr2_on_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fault_addr) |-> (done && fault));

   // A successful completion always grants read and execute
   assert_rx_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (res_r && res_x));
endmodule

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_user;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [31:0] cr0_r, cr3_r, cr4_r, a20_r;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        done, fault, res_r, res_w, res_x;
   logic [2:0]  fault_code;
   logic [31:0] fault_addr, res_paddr;

   always #4 clk = ~clk;

   xlate_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user),
      .cr0(cr0_r), .cr3(cr3_r), .cr4(cr4_r), .a20_mask(a20_r),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr),
      .res_paddr(res_paddr), .res_r(res_r), .res_w(res_w), .res_x(res_x)
   );

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int done_seen = 0;

   logic [31:0] bmem [0:4095];
   logic        eq_we[$];
   logic [31:0] eq_addr[$];
   logic [31:0] eq_data[$];

   logic        e_fault, e_w;
   logic [2:0]  e_code;
   logic [31:0] e_paddr, e_cr2;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
      eq_we.push_back(we);
      eq_addr.push_back(a);
      eq_data.push_back(d);
   endtask

   task automatic set_fault(input logic [31:0] va, input logic wr, input logic usr, input logic p);
      e_fault = 1'b1;
      e_code  = {usr, wr, p};
      e_cr2   = va;
   endtask

   // Behavioural reference of one walk: expected accesses and result
   task automatic model(input logic [31:0] va, input logic wr, input logic usr);
      logic [31:0] da, ta, d, t, n, tmp;
      logic rw, us, pf, wp;
      wp = cr0_r[16];
      e_fault = 1'b0; e_w = 1'b0; e_code = 3'd0;
      if (!cr0_r[31]) begin
         tmp = va & a20_r;
         e_paddr = {tmp[31:12], va[11:0]};
         e_w = 1'b1;
         return;
      end
      da = ((cr3_r & 32'hFFFF_F000) + {20'd0, va[31:22], 2'b00}) & a20_r;
      d  = bmem[da[13:2]];
      push(1'b0, da, 32'd0);
      if (!d[0]) begin set_fault(va, wr, usr, 1'b0); return; end
      if (d[7] && cr4_r[4]) begin
         rw = d[1]; us = d[2];
         pf = usr ? (!us || (wr && !rw)) : (wp && wr && !rw);
         if (pf) begin set_fault(va, wr, usr, 1'b1); return; end
         n = d | 32'h20 | (wr ? 32'h40 : 32'h0);
         if (n != d) push(1'b1, da, n);
         tmp = d & a20_r;
         e_paddr = {tmp[31:22], va[21:0]};
         e_w = n[6] && (usr ? rw : (!wp || rw));
         return;
      end
      if (!d[5]) push(1'b1, da, d | 32'h20);
      ta = ((d & 32'hFFFF_F000) + {20'd0, va[21:12], 2'b00}) & a20_r;
      t  = bmem[ta[13:2]];
      push(1'b0, ta, 32'd0);
      if (!t[0]) begin set_fault(va, wr, usr, 1'b0); return; end
      rw = t[1] & d[1]; us = t[2] & d[2];
      pf = usr ? (!us || (wr && !rw)) : (wp && wr && !rw);
      if (pf) begin set_fault(va, wr, usr, 1'b1); return; end
      n = t | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (n != t) push(1'b1, ta, n);
      tmp = t & a20_r;
      e_paddr = {tmp[31:12], va[11:0]};
      e_w = n[6] && (usr ? rw : (!wp || rw));
   endtask

   // Memory responder and per-cycle comparison of accesses
   initial begin
      int wcnt;
      logic        x_we;
      logic [31:0] x_a, x_d;
      wcnt = 0;
      mem_ack = 1'b0;
      mem_rdata = 32'd0;
      forever begin
         @(negedge clk);
         if (done) done_seen++;
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wcnt < lat) begin
               wcnt++;
            end else begin
               wcnt = 0;
               checks++;
               if (eq_we.size() == 0) begin
                  errors++;
                  $display("FAIL R2 R3 unexpected access: actual %h expected none", mem_addr);
               end else begin
                  x_we = eq_we.pop_front();
                  x_a  = eq_addr.pop_front();
                  x_d  = eq_data.pop_front();
                  chk("R2 R3", "access direction", {31'd0, mem_we}, {31'd0, x_we});
                  chk("R2 R3", "access address", mem_addr, x_a);
                  if (x_we) chk("R9", "write-back data", mem_wdata, x_d);
               end
               if (mem_we) bmem[mem_addr[13:2]] = mem_wdata;
               else        mem_rdata = bmem[mem_addr[13:2]];
               mem_ack = 1'b1;
            end
         end
      end
   end

   task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                       input int l, input bit junk, input string tag);
      int ds;
      lat = l;
      model(va, wr, usr);
      ds = done_seen;
      @(negedge clk); #1;
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
      @(negedge clk); #1;
      if (junk) begin
         req_vaddr = 32'h0080_1000; req_write = 1'b1; req_user = 1'b0;
         repeat (3) begin @(negedge clk); #1; end
      end
      req_valid = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (done) break;
         @(negedge clk); #1;
      end
      chk("R12", "done seen", {31'd0, done}, 32'd1);
      chk(tag, "fault flag", {31'd0, fault}, {31'd0, e_fault});
      if (e_fault) begin
         chk(tag, "error code", {29'd0, fault_code}, {29'd0, e_code});
         chk("R11", "fault address", fault_addr, e_cr2);
      end else begin
         chk(tag, "physical address", res_paddr, e_paddr);
         chk(tag, "write grant", {31'd0, res_w}, {31'd0, e_w});
         chk("R10", "read and exec grant", {30'd0, res_r, res_x}, 32'd3);
         chk("R11", "fault address kept", fault_addr, e_cr2);
      end
      @(negedge clk); #1;
      chk("R12", "done width", {31'd0, done}, 32'd0);
      chk("R12", "ready after walk", {31'd0, req_ready}, 32'd1);
      repeat (2) begin @(negedge clk); #1; end
      chk("R12", "one pulse per request", done_seen, ds + 1);
      chk("R12", "no access when idle", {31'd0, mem_req}, 32'd0);
      chk(tag, "pending accesses", eq_we.size(), 32'd0);
      eq_we.delete(); eq_addr.delete(); eq_data.delete();
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) bmem[i] = 32'd0;
      // Directory at 0x1000, tables at 0x2000 and 0x3000
      bmem[12'h401] = 32'h0000_2027;
      bmem[12'h402] = 32'h0000_2007;
      bmem[12'h403] = 32'h0000_0000;
      bmem[12'h404] = 32'h0000_3025;
      bmem[12'h405] = 32'h0140_0087;
      bmem[12'h801] = 32'h0006_0067;
      bmem[12'h803] = 32'h0005_0007;
      bmem[12'h805] = 32'h0007_0003;
      bmem[12'h806] = 32'h0015_0067;
      bmem[12'hC00] = 32'h0008_0067;

      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
      cr0_r = 32'd0; cr3_r = 32'h0000_1000; cr4_r = 32'd0; a20_r = 32'hFFFF_FFFF;
      e_cr2 = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R12", "reset ready", {31'd0, req_ready}, 32'd1);
      chk("R12", "reset done", {31'd0, done}, 32'd0);
      chk("R12", "reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R11", "reset fault address", fault_addr, 32'd0);

      // R1: paging off, with and without the address mask
      walk(32'h1234_5678, 1'b1, 1'b1, 0, 1'b0, "R1");
      a20_r = 32'hFFEF_FFFF;
      walk(32'h0013_4567, 1'b0, 1'b0, 0, 1'b0, "R1");
      a20_r = 32'hFFFF_FFFF;

      cr0_r = 32'h8000_0000;
      // R3 R9 R10: clean page read sets accessed, no write grant
      walk(32'h0040_3ABC, 1'b0, 1'b1, 1, 1'b0, "R3 R9 R10");
      walk(32'h0040_3ABC, 1'b0, 1'b1, 0, 1'b0, "R9 R10");
      // first write marks dirty
      walk(32'h0040_3ABC, 1'b1, 1'b1, 2, 1'b0, "R9 R10");
      walk(32'h0040_3ABC, 1'b1, 1'b1, 0, 1'b0, "R9 R10");
      // R8: directory entry without accessed bit
      walk(32'h0080_1000, 1'b0, 1'b0, 1, 1'b0, "R8");
      walk(32'h0080_1234, 1'b0, 1'b0, 0, 1'b0, "R8");
      // R4 R11: missing directory entry, missing table entry
      walk(32'h00C0_0010, 1'b1, 1'b1, 0, 1'b0, "R4 R11");
      walk(32'h0040_4000, 1'b0, 1'b0, 1, 1'b0, "R4 R11");
      // R6: user access to supervisor page
      walk(32'h0040_5000, 1'b0, 1'b1, 0, 1'b0, "R6 R9");
      // R6: read-only directory merged with writable table
      walk(32'h0100_0000, 1'b1, 1'b1, 0, 1'b0, "R6");
      walk(32'h0100_0000, 1'b0, 1'b1, 1, 1'b0, "R6 R10");
      // R7: supervisor write on read-only page
      walk(32'h0100_0040, 1'b1, 1'b0, 0, 1'b0, "R7");
      cr0_r = 32'h8001_0000;
      walk(32'h0100_0040, 1'b1, 1'b0, 0, 1'b0, "R7");
      walk(32'h0100_0040, 1'b0, 1'b0, 0, 1'b0, "R7 R10");
      cr0_r = 32'h8000_0000;
      // R5: large page with and without the extension
      cr4_r = 32'h0000_0010;
      walk(32'h0141_2345, 1'b0, 1'b0, 1, 1'b0, "R5");
      walk(32'h0141_2345, 1'b1, 1'b1, 0, 1'b0, "R5 R10");
      cr4_r = 32'h0000_0000;
      walk(32'h0141_2345, 1'b0, 1'b0, 0, 1'b0, "R5");
      // R2: address mask on directory, table and frame
      cr3_r = 32'h0010_1000; a20_r = 32'hFFEF_FFFF;
      walk(32'h0040_6123, 1'b0, 1'b0, 2, 1'b0, "R2 R3");
      cr3_r = 32'h0000_1000; a20_r = 32'hFFFF_FFFF;
      // R12: request held during a walk is ignored
      walk(32'h0040_3ABC, 1'b0, 1'b0, 2, 1'b1, "R12");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule